// File: doc/BRIEF.md
# DMA Service Timing Sequencer

This block steps one direct-memory-access service through its bus states, one state per clock, and decodes from the current state the strobes that move one data item per transfer. It starts from idle when the granted channel raises its request. It then asks the processor for the bus with a hold request and waits in a hold state until the hold acknowledge arrives. After that it runs the working states of a transfer.

For transfers between an I/O device and memory, data goes straight across the system bus. The I/O read strobe is paired with the memory write strobe, or the memory read strobe with the I/O write strobe, and no data passes through the block. For memory-to-memory copies the block runs an eight-state sequence instead. It reads a byte into an internal holding register during the read half, then drives that byte back out during the write half. A low ready input holds the machine in a wait state just before the last state of a transfer or half-transfer.

The sequence after each transfer depends on the service mode:
- **Single mode** gives the bus back after every transfer.
- **Block mode** keeps going until the terminal count or an external stop.
- **Demand mode** also stops when the request falls.

Arbitration and the address and count registers sit outside; they use the per-transfer step pulse to advance.

Top module: `dma_xfer_sequencer`

## Requirements
- R1: `seq_state` reports the state with this code: IDLE=0, HOLD=1, T1=2, T2=3, T3=4, T4=5, WAIT=6, R1=7, R2=8, R3=9, R4=10, W1=11, W2=12, W3=13, W4=14. Reset gives IDLE with every strobe, `addr_en`, `addr_latch`, `data_oe`, `xfer_step`, `svc_done` and `hold_req` low. The state moves at most one step per clock.
- R2: IDLE goes to HOLD when `chan_req` is high. In HOLD a low `chan_req` returns the machine to IDLE; this check comes first. Otherwise a high `hold_ack` goes to R1 when `mem_to_mem`=1, or to T1 when it is 0. Otherwise the machine stays in HOLD.
- R3: In T3, R3 or W3 with `rdy_in` low the machine enters WAIT. It stays there while `rdy_in` is low, then goes to T4, R4 or W4 respectively. Without a wait, T1→T2→T3→T4, R1→R2→R3→R4→W1→W2→W3→W4.
- R4: Strobe pairing depends on `io_to_mem`. With `io_to_mem`=1, `io_rd` is high in T2, T3, WAIT and T4, and `mem_wr` is high in T3, WAIT and T4. With `io_to_mem`=0, `mem_rd` and `io_wr` take those same roles. No strobe is active in IDLE, HOLD or T1.
- R5: `addr_en` is high in every state except IDLE and HOLD. `addr_latch` is high only in T1, R1 and W1.
- R6: `hold_req` is high in every state except IDLE.
- R7: In the memory-to-memory sequence, `mem_rd` is high in R2, R3, R4 and in a wait of the read half. `mem_wr` is high in W3, W4 and in a wait of the write half. `io_rd` and `io_wr` stay low.
- R8: `mem_rd_data` is captured on the clock edge that leaves R4. `data_oe` is high in W1 to W4 and in a wait of the write half. `data_out` shows the captured byte.
- R9: `xfer_mode` 01 (single) and 11 (treated as single) go from T4 or W4 to IDLE after every transfer, even with `chan_req` held high.
- R10: `xfer_mode` 10 (block) goes from T4 to T1 or from W4 to R1 whatever the level of `chan_req`.
- R11: `xfer_mode` 00 (demand) goes from T4/W4 back to T1/R1 if `chan_req` is high in that last state, and to IDLE if it is low.
- R12: `xfer_step` is high in every T4 and W4. When `term_cnt` or `ext_stop` is high in that state, or a stop was latched, the machine goes to IDLE in any mode. `svc_done` is high in that same cycle.
- R13: An `ext_stop` pulse seen in any working state (not IDLE or HOLD) is remembered. It ends the service at the next T4 or W4. The latch clears on return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | 1 | Request of the channel chosen by arbitration |
| hold_ack | input | 1 | Processor has released the bus |
| rdy_in | input | 1 | Low extends the transfer with wait states |
| xfer_mode | input | 2 | 00 demand, 01 single, 10 block, 11 as single |
| io_to_mem | input | 1 | 1: I/O read to memory write; 0: memory read to I/O write |
| mem_to_mem | input | 1 | 1: run the memory-to-memory sequence |
| term_cnt | input | 1 | Current transfer is the last one |
| ext_stop | input | 1 | External end-of-process request |
| mem_rd_data | input | DATA_W | Memory data for the copy read half |
| seq_state | output | 4 | State code (R1) |
| hold_req | output | 1 | Bus request to the processor |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_en | output | 1 | Address drivers enabled |
| addr_latch | output | 1 | Strobe latching the upper address byte |
| data_out | output | DATA_W | Held byte for the copy write half |
| data_oe | output | 1 | Drive enable for `data_out` |
| xfer_step | output | 1 | One transfer completes this cycle |
| svc_done | output | 1 | Service ends this cycle by count or stop |

## Verification
The bench steps a behavioural reference alongside the block and compares every output on each clock.

It runs three service modes, and each is told apart by how the request is handled:
- Single mode keeps the request held and must see the bus released between transfers.
- Block mode drops the request right after the grant and must keep going.
- Demand mode drops the request mid-service and must stop after exactly one more transfer.

Both I/O directions are run, which separates the two strobe pairings. A toggling ready line forces waits in every half of both sequences. An aborted hold, an early stop pulse, and a copy of two distinct bytes check the stop latch, the withdrawal path and the holding register.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_HOLD = 4'd1,
        S_T1   = 4'd2,
        S_T2   = 4'd3,
        S_T3   = 4'd4,
        S_T4   = 4'd5,
        S_WAIT = 4'd6,
        S_R1   = 4'd7,
        S_R2   = 4'd8,
        S_R3   = 4'd9,
        S_R4   = 4'd10,
        S_W1   = 4'd11,
        S_W2   = 4'd12,
        S_W3   = 4'd13,
        S_W4   = 4'd14
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_DEMAND = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_BLOCK  = 2'b10,
        MODE_RSVD   = 2'b11
    } svc_mode_e;

    function automatic logic is_working(input seq_state_e s);
        return (s != S_IDLE) && (s != S_HOLD);
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_req,
    input  logic       hold_ack,
    input  logic       rdy_in,
    input  logic [1:0] xfer_mode,
    input  logic       mem_to_mem,
    input  logic       term_cnt,
    input  logic       ext_stop,
    output seq_state_e state_q,
    output seq_state_e wait_ret_q,
    output logic       xfer_step,
    output logic       svc_done
);

    seq_state_e state_d;
    seq_state_e wait_ret_d;
    logic       stop_q;
    logic       stop_d;
    logic       end_hit;
    logic       last_state;
    seq_state_e restart;
    svc_mode_e  mode;

    assign mode       = svc_mode_e'(xfer_mode);
    assign last_state = (state_q == S_T4) || (state_q == S_W4);
    assign end_hit    = term_cnt || ext_stop || stop_q;
    assign restart    = (state_q == S_W4) ? S_R1 : S_T1;
    assign xfer_step  = last_state;
    assign svc_done   = last_state && end_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            wait_ret_q <= S_T4;
            stop_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            wait_ret_q <= wait_ret_d;
            stop_q     <= stop_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        wait_ret_d = wait_ret_q;
        unique case (state_q)
            S_IDLE: if (chan_req) state_d = S_HOLD;
            S_HOLD: begin
                if (!chan_req)     state_d = S_IDLE;
                else if (hold_ack) state_d = mem_to_mem ? S_R1 : S_T1;
            end
            S_T1: state_d = S_T2;
            S_T2: state_d = S_T3;
            S_T3: begin
                if (rdy_in) state_d = S_T4;
                else begin
                    state_d    = S_WAIT;
                    wait_ret_d = S_T4;
                end
            end
            S_WAIT: if (rdy_in) state_d = wait_ret_q;
            S_R1: state_d = S_R2;
            S_R2: state_d = S_R3;
            S_R3: begin
                if (rdy_in) state_d = S_R4;
                else begin
                    state_d    = S_WAIT;
                    wait_ret_d = S_R4;
                end
            end
            S_R4: state_d = S_W1;
            S_W1: state_d = S_W2;
            S_W2: state_d = S_W3;
            S_W3: begin
                if (rdy_in) state_d = S_W4;
                else begin
                    state_d    = S_WAIT;
                    wait_ret_d = S_W4;
                end
            end
            S_T4, S_W4: begin
                if (end_hit) state_d = S_IDLE;
                else begin
                    unique case (mode)
                        MODE_BLOCK:  state_d = restart;
                        MODE_DEMAND: state_d = chan_req ? restart : S_IDLE;
                        MODE_SINGLE,
                        MODE_RSVD:   state_d = S_IDLE;
                        default:     state_d = S_IDLE;
                    endcase
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // stop latch
    always_comb begin
        if (state_d == S_IDLE)                   stop_d = 1'b0;
        else if (is_working(state_q) && ext_stop) stop_d = 1'b1;
        else                                     stop_d = stop_q;
    end

    AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_T3) && !rdy_in) |=> (state_q == S_WAIT)); // R3
    AST_SINGLE_GIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_T4) && (xfer_mode == 2'b01)) |=> (state_q == S_IDLE)); // R9
    AST_BLOCK_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_T4) && (xfer_mode == 2'b10) && !end_hit) |=> (state_q == S_T1)); // R10

endmodule

// File: rtl/dma_seq_strobes.sv
module dma_seq_strobes
    import dma_seq_pkg::*;
(
    input  seq_state_e state_q,
    input  seq_state_e wait_ret_q,
    input  logic       io_to_mem,
    output logic       hold_req,
    output logic       io_rd,
    output logic       io_wr,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       addr_en,
    output logic       addr_latch,
    output logic       capture,
    output logic       data_oe
);

    logic io_rd_ph;
    logic io_wr_ph;

    // output decode
    always_comb begin
        hold_req   = (state_q != S_IDLE);
        addr_en    = is_working(state_q);
        addr_latch = 1'b0;
        io_rd_ph   = 1'b0;
        io_wr_ph   = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        io_rd      = 1'b0;
        io_wr      = 1'b0;
        capture    = 1'b0;
        data_oe    = 1'b0;
        unique case (state_q)
            S_IDLE, S_HOLD: ;
            S_T1, S_R1:     addr_latch = 1'b1;
            S_W1: begin
                addr_latch = 1'b1;
                data_oe    = 1'b1;
            end
            S_T2: io_rd_ph = 1'b1;
            S_T3, S_T4: begin
                io_rd_ph = 1'b1;
                io_wr_ph = 1'b1;
            end
            S_WAIT: begin
                unique case (wait_ret_q)
                    S_R4: mem_rd = 1'b1;
                    S_W4: begin
                        mem_wr  = 1'b1;
                        data_oe = 1'b1;
                    end
                    default: begin
                        io_rd_ph = 1'b1;
                        io_wr_ph = 1'b1;
                    end
                endcase
            end
            S_R2, S_R3: mem_rd = 1'b1;
            S_R4: begin
                mem_rd  = 1'b1;
                capture = 1'b1;
            end
            S_W2: data_oe = 1'b1;
            S_W3, S_W4: begin
                mem_wr  = 1'b1;
                data_oe = 1'b1;
            end
            default: ;
        endcase
        // first phase reads the source, second writes the target
        if (io_to_mem) begin
            io_rd  = io_rd_ph;
            mem_wr = mem_wr | io_wr_ph;
        end else begin
            mem_rd = mem_rd | io_rd_ph;
            io_wr  = io_wr_ph;
        end
    end

endmodule

// File: rtl/dma_seq_tmpreg.sv
module dma_seq_tmpreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (capture) dout <= din;
    end

endmodule

// File: rtl/dma_xfer_sequencer.sv
module dma_xfer_sequencer
    import dma_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_req,
    input  logic              hold_ack,
    input  logic              rdy_in,
    input  logic [1:0]        xfer_mode,
    input  logic              io_to_mem,
    input  logic              mem_to_mem,
    input  logic              term_cnt,
    input  logic              ext_stop,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [3:0]        seq_state,
    output logic              hold_req,
    output logic              io_rd,
    output logic              io_wr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              addr_en,
    output logic              addr_latch,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              xfer_step,
    output logic              svc_done
);

    seq_state_e state_q;
    seq_state_e wait_ret_q;
    logic       capture;

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_req   (chan_req),
        .hold_ack   (hold_ack),
        .rdy_in     (rdy_in),
        .xfer_mode  (xfer_mode),
        .mem_to_mem (mem_to_mem),
        .term_cnt   (term_cnt),
        .ext_stop   (ext_stop),
        .state_q    (state_q),
        .wait_ret_q (wait_ret_q),
        .xfer_step  (xfer_step),
        .svc_done   (svc_done)
    );

    dma_seq_strobes u_strb (
        .state_q    (state_q),
        .wait_ret_q (wait_ret_q),
        .io_to_mem  (io_to_mem),
        .hold_req   (hold_req),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .addr_en    (addr_en),
        .addr_latch (addr_latch),
        .capture    (capture),
        .data_oe    (data_oe)
    );

    dma_seq_tmpreg #(.DATA_W(DATA_W)) u_tmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_rd_data),
        .dout    (data_out)
    );

    assign seq_state = state_q;

    AST_ADDR_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> hold_req); // R6
    AST_IO_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr)); // R4
    AST_COPY_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!io_rd && !io_wr && !mem_rd)); // R7
    AST_DONE_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |-> xfer_step); // R12
    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |=> !addr_latch); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out)); // R8

endmodule

// File: tb/dma_xfer_sequencer_tb.sv
module dma_xfer_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_req = 1'b0;
    logic          rdy_in = 1'b1;
    logic [1:0]    xfer_mode = 2'b01;
    logic          io_to_mem = 1'b1;
    logic          mem_to_mem = 1'b0;
    logic          term_cnt = 1'b0;
    logic          ext_stop = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          ack_auto = 1'b1;
    logic          ack_q = 1'b0;
    logic          rdy_toggle = 1'b0;
    logic          hold_ack;

    logic [3:0]    seq_state;
    logic          hold_req, io_rd, io_wr, mem_rd, mem_wr;
    logic          addr_en, addr_latch, data_oe, xfer_step, svc_done;
    logic [DW-1:0] data_out;

    int total = 0;
    int bad = 0;
    int steps = 0;
    int dones = 0;
    int cycles = 0;

    // reference model state
    int  m_st = 0;
    int  m_ret = 5;
    bit  m_stop = 0;
    int  m_tmp = 0;

    assign hold_ack = ack_auto & ack_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_sequencer #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .hold_ack(hold_ack),
        .rdy_in(rdy_in), .xfer_mode(xfer_mode), .io_to_mem(io_to_mem),
        .mem_to_mem(mem_to_mem), .term_cnt(term_cnt), .ext_stop(ext_stop),
        .mem_rd_data(mem_rd_data), .seq_state(seq_state), .hold_req(hold_req),
        .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_en(addr_en), .addr_latch(addr_latch), .data_out(data_out),
        .data_oe(data_oe), .xfer_step(xfer_step), .svc_done(svc_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // simple processor: acknowledges one cycle after seeing the hold request
    always @(posedge clk) begin
        #1;
        ack_q = hold_req;
        if (rdy_toggle) rdy_in = ~rdy_in;
    end

    // behavioural reference, advanced on the clock with the inputs of that cycle
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ret = 5; m_stop = 0; m_tmp = 0;
        end else begin
            int nx;
            bit fin;
            nx = m_st;
            fin = term_cnt || ext_stop || m_stop;
            if (m_st == 10) m_tmp = int'(mem_rd_data);
            if (m_st == 0) begin
                if (chan_req) nx = 1;
            end else if (m_st == 1) begin
                if (!chan_req) nx = 0;
                else if (hold_ack) nx = mem_to_mem ? 7 : 2;
            end else if (m_st == 4 || m_st == 9 || m_st == 13) begin
                if (rdy_in) nx = m_st + 1;
                else begin
                    m_ret = m_st + 1;
                    nx = 6;
                end
            end else if (m_st == 6) begin
                if (rdy_in) nx = m_ret;
            end else if (m_st == 5 || m_st == 14) begin
                if (fin) nx = 0;
                else if (xfer_mode == 2'b10) nx = (m_st == 5) ? 2 : 7;
                else if (xfer_mode == 2'b00 && chan_req) nx = (m_st == 5) ? 2 : 7;
                else nx = 0;
            end else begin
                nx = m_st + 1;
            end
            if (nx == 0) m_stop = 0;
            else if (m_st >= 2 && ext_stop) m_stop = 1;
            m_st = nx;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit wk, ioph_r, ioph_w, cp_r, cp_w, oe, stp;
            wk     = (m_st >= 2);
            ioph_r = (m_st >= 3 && m_st <= 5) || (m_st == 6 && m_ret == 5);
            ioph_w = (m_st == 4 || m_st == 5) || (m_st == 6 && m_ret == 5);
            cp_r   = (m_st >= 8 && m_st <= 10) || (m_st == 6 && m_ret == 10);
            cp_w   = (m_st == 13 || m_st == 14) || (m_st == 6 && m_ret == 14);
            oe     = (m_st >= 11 && m_st <= 14) || (m_st == 6 && m_ret == 14);
            stp    = (m_st == 5 || m_st == 14);
            check(int'(seq_state) == m_st, "R1/R2/R3/R9/R10/R11 state", int'(seq_state), m_st);
            check(hold_req == (m_st != 0), "R6 hold_req", int'(hold_req), int'(m_st != 0));
            check(addr_en == wk, "R5 addr_en", int'(addr_en), int'(wk));
            check(addr_latch == (m_st == 2 || m_st == 7 || m_st == 11), "R5 addr_latch",
                  int'(addr_latch), int'(m_st == 2 || m_st == 7 || m_st == 11));
            check(io_rd == (io_to_mem && ioph_r), "R4 io_rd", int'(io_rd), int'(io_to_mem && ioph_r));
            check(io_wr == (!io_to_mem && ioph_w), "R4 io_wr", int'(io_wr), int'(!io_to_mem && ioph_w));
            check(mem_rd == ((!io_to_mem && ioph_r) || cp_r), "R4/R7 mem_rd",
                  int'(mem_rd), int'((!io_to_mem && ioph_r) || cp_r));
            check(mem_wr == ((io_to_mem && ioph_w) || cp_w), "R4/R7 mem_wr",
                  int'(mem_wr), int'((io_to_mem && ioph_w) || cp_w));
            check(data_oe == oe, "R8 data_oe", int'(data_oe), int'(oe));
            if (oe) check(int'(data_out) == m_tmp, "R8 data_out", int'(data_out), m_tmp);
            check(xfer_step == stp, "R12 xfer_step", int'(xfer_step), int'(stp));
            check(svc_done == (stp && (term_cnt || ext_stop || m_stop)), "R12/R13 svc_done",
                  int'(svc_done), int'(stp && (term_cnt || ext_stop || m_stop)));
            if (xfer_step) steps++;
            if (svc_done) dones++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_steps(input int n);
        while (steps < n) tick(1);
    endtask

    task automatic wait_idle();
        tick(1);
        while (seq_state != 4'd0) tick(1);
        tick(2);
    endtask

    task automatic wait_addr();
        while (!addr_en) tick(1);
    endtask

    initial begin
        int s0;
        tick(3);
        // R1: reset state
        check(seq_state == 4'd0 && !hold_req && !addr_en && !io_rd && !mem_wr && !data_oe,
              "R1 reset", int'(seq_state), 0);
        rst_n = 1'b1;
        tick(2);

        // R9: single, I/O to memory, request held throughout
        s0 = steps;
        xfer_mode = 2'b01; io_to_mem = 1'b1; chan_req = 1'b1;
        wait_steps(s0 + 2);
        chan_req = 1'b0;
        wait_idle();
        check(steps - s0 == 2, "R9 single transfers", steps - s0, 2);

        // R10/R12/R3: block, memory to I/O, request dropped after grant, waits, count at 3
        s0 = steps;
        xfer_mode = 2'b10; io_to_mem = 1'b0; rdy_toggle = 1'b1; chan_req = 1'b1;
        wait_addr();
        chan_req = 1'b0;
        wait_steps(s0 + 2);
        term_cnt = 1'b1;
        wait_steps(s0 + 3);
        tick(1);
        term_cnt = 1'b0;
        wait_idle();
        check(steps - s0 == 3, "R10 block until count", steps - s0, 3);
        rdy_toggle = 1'b0; rdy_in = 1'b1;

        // R11: demand, request removed during the second transfer
        s0 = steps;
        xfer_mode = 2'b00; io_to_mem = 1'b1; chan_req = 1'b1;
        wait_steps(s0 + 1);
        tick(1);
        chan_req = 1'b0;
        wait_idle();
        check(steps - s0 == 2, "R11 demand stops on request", steps - s0, 2);

        // R2: hold withdrawn before acknowledge
        s0 = steps;
        ack_auto = 1'b0; chan_req = 1'b1;
        tick(3);
        check(hold_req == 1'b1 && seq_state == 4'd1, "R2 waiting in hold", int'(seq_state), 1);
        chan_req = 1'b0;
        tick(2);
        check(hold_req == 1'b0 && steps == s0, "R2 withdrawn", int'(hold_req), 0);
        ack_auto = 1'b1;

        // R13: stop pulse early in a block service
        s0 = steps;
        xfer_mode = 2'b10; chan_req = 1'b1;
        wait_addr();
        ext_stop = 1'b1;
        tick(1);
        ext_stop = 1'b0;
        chan_req = 1'b0;
        wait_idle();
        check(steps - s0 == 1, "R13 latched stop", steps - s0, 1);

        // R7/R8/R3: block memory copy of two bytes with waits
        s0 = steps;
        mem_to_mem = 1'b1; rdy_toggle = 1'b1; mem_rd_data = 8'hA5; chan_req = 1'b1;
        wait_addr();
        chan_req = 1'b0;
        wait_steps(s0 + 1);
        mem_rd_data = 8'h3C; term_cnt = 1'b1;
        wait_steps(s0 + 2);
        tick(1);
        term_cnt = 1'b0;
        wait_idle();
        check(steps - s0 == 2, "R7 copy transfers", steps - s0, 2);
        check(data_out == 8'h3C, "R8 last byte held", int'(data_out), 8'h3C);
        rdy_toggle = 1'b0; rdy_in = 1'b1; mem_to_mem = 1'b0;

        // R9: reserved mode code behaves as single
        s0 = steps;
        xfer_mode = 2'b11; io_to_mem = 1'b0; chan_req = 1'b1;
        wait_steps(s0 + 2);
        chan_req = 1'b0;
        wait_idle();
        check(steps - s0 == 2, "R9 reserved as single", steps - s0, 2);
        check(dones == 3, "R12 done pulses", dones, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule